// File: doc/BRIEF.md
# Quad SPI flash read controller

This block is a host-side master that fetches data from a serial NOR flash over four bidirectional IO lines. A request carries a 24-bit start address, a byte count and a read kind. The block drops chip select, toggles the serial clock at half the system clock, and sends the opcode, the address and, for quad-address reads, a mode byte. It then runs a programmable number of turnaround clocks and assembles the returned nibbles into bytes. Each byte is marked by a single-cycle strobe.

Three read kinds are supported:

- **Legacy quad-output read.** The opcode and the address go out one bit per clock on line 0.
- **Quad-address read with exit mode byte.** The opcode goes out serially, and the address and mode byte go out a nibble per clock.
- **Quad-address read with keep mode byte.** It has the same layout, but the mode byte tells the flash that the next access is the same read.

The block remembers whether the flash was left in that implied-command state. While it is, the next request of any kind skips the opcode and sends only the address nibbles and a fresh mode byte. A request of any kind other than the keep kind then takes the flash back to explicit opcodes.

Top module: `qfr_ctrl`

## Requirements
- R1: After reset, `cs_no` is 1, `sclk_o` is 0, `io_oe_o` is 0, `rd_valid_o` is 0, `req_ready_o` is 1 and `implied_o` is 0.
- R2: `sclk_o` has a period of two `clk_i` cycles. `cs_no` falls exactly one `clk_i` cycle before the first rising `sclk_o` edge. `io_o` and `io_oe_o` never change at a rising `sclk_o` edge.
- R3: `req_kind_i` = 0 with `implied_o` = 0 sends opcode 0x6B and then the 24 address bits, all MSB first on `io_o[0]` with `io_oe_o` = 4'b0001. That is 32 rising edges, with no mode byte.
- R4: `req_kind_i` of 1, 2 or 3 with `implied_o` = 0 sends opcode 0xEB serially on `io_o[0]` (8 edges). It then sends 6 address nibbles, MSB nibble first, on `io_o[3:0]` with `io_oe_o` = 4'hF, followed by 2 mode nibbles, high nibble first.
- R5: The mode byte is 0xA0 when `req_kind_i` = 2 and 0xFF otherwise. After a request that sends a mode byte, `implied_o` is 1 exactly when the mode byte was 0xA0. A legacy read sent with `implied_o` = 0 leaves it at 0.
- R6: When `implied_o` = 1 at acceptance, the opcode phase is omitted for every kind, legacy included. The header is then the 6 address nibbles plus the 2 mode nibbles (8 edges).
- R7: After the header, exactly `latency_i` rising edges follow (0 to 15), with `io_oe_o` = 0.
- R8: For `req_len_i` = N, 2(N+1) data edges follow with `io_oe_o` = 0. `io_i` is sampled on each rising edge, high nibble first. N+1 bytes appear on `rd_data_o`, byte k being the flash content at address+k, each with a one-cycle `rd_valid_o` pulse.
- R9: `req_ready_o` is 0 while a transfer runs. `cs_no` returns to 1 on the falling edge after the last data edge, with no extra `sclk_o` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, accepted when ready |
| req_ready_o | output | 1 | Controller idle, can accept a request |
| req_kind_i | input | 2 | 0 legacy quad-output, 1 quad-address exit, 2 quad-address keep |
| req_addr_i | input | 24 | Start byte address |
| req_len_i | input | 8 | Byte count minus one |
| latency_i | input | 4 | Turnaround clocks after the header |
| cs_no | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock |
| io_o | output | 4 | IO line output values |
| io_oe_o | output | 4 | IO line output enables |
| io_i | input | 4 | IO line input values |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | One-cycle strobe for rd_data_o |
| implied_o | output | 1 | Flash is left in implied-command mode |

## Verification
A wrong implied-command flag shows at the very next request. The header grows or shrinks by eight serial opcode bits, so the address nibbles arrive on the wrong edges, and the flash model returns data for the wrong address or at the wrong turnaround. A wrong phase counter shows within one transfer as a miscounted total of clock edges, misplaced output enables, or bytes that are shifted by a nibble. The sweep covers every latency value, several lengths, and a kind order that hits every transition of the flag.

// File: rtl/qfr_pkg.sv
package qfr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_LAT, PH_DATA
  } phase_e;

  localparam logic [1:0] KIND_QOUT     = 2'd0;
  localparam logic [1:0] KIND_QIO_KEEP = 2'd2;

  localparam logic [7:0] OPC_QOUT  = 8'h6B;
  localparam logic [7:0] OPC_QIO   = 8'hEB;
  localparam logic [7:0] MODE_KEEP = 8'hA0;
  localparam logic [7:0] MODE_EXIT = 8'hFF;
endpackage

// File: rtl/qfr_tx.sv
module qfr_tx #(
  parameter int SH_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SH_W-1:0] load_val_i,
  input  logic            shift_i,
  input  logic            drive_i,
  input  logic            quad_i,
  output logic [3:0]      io_o,
  output logic [3:0]      io_oe_o
);
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (load_i) sh_q <= load_val_i;
    else if (shift_i) sh_q <= quad_i ? {sh_q[SH_W-5:0], 4'h0} : {sh_q[SH_W-2:0], 1'b0};
  end

  always_comb begin
    io_o    = 4'h0;
    io_oe_o = 4'h0;
    if (drive_i) begin
      if (quad_i) begin
        io_o    = sh_q[SH_W-1 -: 4];
        io_oe_o = 4'hF;
      end else begin
        io_o    = {3'b000, sh_q[SH_W-1]};
        io_oe_o = 4'h1;
      end
    end
  end
endmodule

// File: rtl/qfr_rx.sv
module qfr_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sample_i,
  input  logic [3:0] io_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       done_o
);
  logic [3:0] hi_q;
  logic       lo_q;

  assign done_o = sample_i & lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= 1'b0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) lo_q <= 1'b0;
      else if (sample_i) begin
        if (!lo_q) begin
          hi_q <= io_i;
          lo_q <= 1'b1;
        end else begin
          byte_o  <= {hi_q, io_i};
          valid_o <= 1'b1;
          lo_q    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/qfr_ctrl.sv
module qfr_ctrl
  import qfr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [LAT_W-1:0]  latency_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              implied_o
);
  localparam int SH_W  = ADDR_W + 16;
  localparam int NIB_N = ADDR_W / 4;
  localparam int CNT_W = $clog2(ADDR_W);

  phase_e             ph_q, lat_ph;
  logic [CNT_W-1:0]   cnt_q, lat_cnt;
  logic               quad_q, last_q, implied_q, sclk_q, cs_nq;
  logic [LAT_W-1:0]   lat_q;
  logic [LEN_W-1:0]   left_q;
  logic               accept, quad_path, rx_done;
  logic [7:0]         opc, mode;
  logic [SH_W-1:0]    load_val;
  logic               hdr_ph;

  assign accept    = (ph_q == PH_IDLE) && req_valid_i;
  assign quad_path = (req_kind_i != KIND_QOUT) || implied_q;
  assign opc       = quad_path ? OPC_QIO : OPC_QOUT;
  assign mode      = (req_kind_i == KIND_QIO_KEEP) ? MODE_KEEP : MODE_EXIT;
  assign load_val  = implied_q ? {req_addr_i, mode, 8'h00} : {opc, req_addr_i, mode};
  assign hdr_ph    = (ph_q == PH_CMD) || (ph_q == PH_ADDR) || (ph_q == PH_MODE);
  assign lat_ph    = (lat_q == '0) ? PH_DATA : PH_LAT;
  assign lat_cnt   = CNT_W'(lat_q - LAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      quad_q    <= 1'b0;
      lat_q     <= '0;
      left_q    <= '0;
      last_q    <= 1'b0;
      implied_q <= 1'b0;
      sclk_q    <= 1'b0;
      cs_nq     <= 1'b1;
    end else if (ph_q == PH_IDLE) begin
      if (req_valid_i) begin
        cs_nq     <= 1'b0;
        quad_q    <= quad_path;
        lat_q     <= latency_i;
        left_q    <= req_len_i;
        last_q    <= 1'b0;
        implied_q <= quad_path && (req_kind_i == KIND_QIO_KEEP);
        if (implied_q) begin
          ph_q  <= PH_ADDR;
          cnt_q <= CNT_W'(NIB_N - 1);
        end else begin
          ph_q  <= PH_CMD;
          cnt_q <= CNT_W'(7);
        end
      end
    end else if (!sclk_q) begin
      sclk_q <= 1'b1;
      if (rx_done) begin
        if (left_q == '0) last_q <= 1'b1;
        else left_q <= left_q - 1'b1;
      end
    end else begin
      sclk_q <= 1'b0;
      unique case (ph_q)
        PH_CMD:
          if (cnt_q == '0) begin
            ph_q  <= PH_ADDR;
            cnt_q <= quad_q ? CNT_W'(NIB_N - 1) : CNT_W'(ADDR_W - 1);
          end else cnt_q <= cnt_q - 1'b1;
        PH_ADDR:
          if (cnt_q == '0) begin
            if (quad_q) begin
              ph_q  <= PH_MODE;
              cnt_q <= CNT_W'(1);
            end else begin
              ph_q  <= lat_ph;
              cnt_q <= lat_cnt;
            end
          end else cnt_q <= cnt_q - 1'b1;
        PH_MODE:
          if (cnt_q == '0) begin
            ph_q  <= lat_ph;
            cnt_q <= lat_cnt;
          end else cnt_q <= cnt_q - 1'b1;
        PH_LAT:
          if (cnt_q == '0) ph_q <= PH_DATA;
          else cnt_q <= cnt_q - 1'b1;
        PH_DATA:
          if (last_q) begin
            ph_q  <= PH_IDLE;
            cs_nq <= 1'b1;
          end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  qfr_tx #(.SH_W(SH_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (load_val),
    .shift_i    (sclk_q && hdr_ph),
    .drive_i    (hdr_ph),
    .quad_i     ((ph_q == PH_MODE) || ((ph_q == PH_ADDR) && quad_q)),
    .io_o       (io_o),
    .io_oe_o    (io_oe_o)
  );

  qfr_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .sample_i (!sclk_q && (ph_q == PH_DATA)),
    .io_i     (io_i),
    .byte_o   (rd_data_o),
    .valid_o  (rd_valid_o),
    .done_o   (rx_done)
  );

  assign req_ready_o = (ph_q == PH_IDLE);
  assign cs_no       = cs_nq;
  assign sclk_o      = sclk_q;
  assign implied_o   = implied_q;
endmodule

// File: rtl/qfr_chk.sv
module qfr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_no,
  input logic       sclk_o,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       rd_valid_o,
  input logic       req_ready_o,
  input logic       implied_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (io_oe_o == 4'h0) && !sclk_o);

  p_sclk_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  p_launch_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(io_o) && $stable(io_oe_o));

  p_sclk_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);

  p_oe_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'h0) || (io_oe_o == 4'h1) || (io_oe_o == 4'hF));

  p_implied_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (req_ready_o || $stable(implied_o)));

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);
endmodule

bind qfr_ctrl qfr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .io_o        (io_o),
  .io_oe_o     (io_oe_o),
  .rd_valid_o  (rd_valid_o),
  .req_ready_o (req_ready_o),
  .implied_o   (implied_o)
);

// File: tb/sim_qfr_ctrl.sv
`timescale 1ns/1ps
module sim_qfr_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [23:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic [3:0]  latency_i = '0;
  logic [3:0]  io_i = '0;
  logic        req_ready_o, cs_no, sclk_o, rd_valid_o, implied_o;
  logic [3:0]  io_o, io_oe_o;
  logic [7:0]  rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  qfr_ctrl u0 (.*);

  int         rise_cnt, hdr_n, lat_n, nb, bad_pulse;
  logic [3:0] rec_oe [64];
  logic [3:0] rec_io [64];
  logic [3:0] exp_oe [64];
  logic [3:0] exp_io [64];
  logic [7:0] got [16];
  logic [23:0] cur_addr;
  logic       prev_valid;
  realtime    t_cs, t_r0, t_r1;
  bit         exp_imp = 0;

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge cs_no) t_cs = $realtime;

  always @(posedge sclk_o) begin
    if (rise_cnt < 64) begin
      rec_oe[rise_cnt] = io_oe_o;
      rec_io[rise_cnt] = io_o;
    end
    if (rise_cnt == 0) t_r0 = $realtime;
    if (rise_cnt == 1) t_r1 = $realtime;
    rise_cnt++;
  end

  // flash model: launches data nibbles on the falling edge
  always @(negedge sclk_o) begin
    int k;
    k = rise_cnt - hdr_n - lat_n;
    if (!cs_no && k >= 0) begin
      logic [7:0] b;
      b = fdat(cur_addr + 24'(k / 2));
      io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  always @(negedge clk_i) begin
    if (rd_valid_o) begin
      if (prev_valid) bad_pulse++;
      if (nb < 16) got[nb] = rd_data_o;
      nb++;
    end
    prev_valid = rd_valid_o;
  end

  task automatic run(input int kind, input logic [23:0] addr, input int len, input int lat);
    bit skip, quadp;
    logic [7:0] opc, mode;
    int idx, bad;
    string htag;
    skip  = exp_imp;
    quadp = (kind != 0) || skip;
    opc   = quadp ? 8'hEB : 8'h6B;
    mode  = (kind == 2) ? 8'hA0 : 8'hFF;
    htag  = skip ? "R6 header" : (quadp ? "R4 header" : "R3 header");
    idx = 0;
    if (!skip)
      for (int b = 7; b >= 0; b--) begin exp_oe[idx] = 4'h1; exp_io[idx] = {3'b0, opc[b]}; idx++; end
    if (quadp) begin
      for (int n = 5; n >= 0; n--) begin exp_oe[idx] = 4'hF; exp_io[idx] = addr[4*n +: 4]; idx++; end
      exp_oe[idx] = 4'hF; exp_io[idx] = mode[7:4]; idx++;
      exp_oe[idx] = 4'hF; exp_io[idx] = mode[3:0]; idx++;
    end else
      for (int b = 23; b >= 0; b--) begin exp_oe[idx] = 4'h1; exp_io[idx] = {3'b0, addr[b]}; idx++; end
    hdr_n = idx; lat_n = lat; cur_addr = addr;
    rise_cnt = 0; nb = 0; bad_pulse = 0;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = 2'(kind); req_addr_i = addr;
    req_len_i = 8'(len); latency_i = 4'(lat);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9 busy", req_ready_o, 0);
    while (!cs_no) @(negedge clk_i);

    bad = 0;
    for (int i = 0; i < hdr_n; i++)
      if (rec_oe[i] !== exp_oe[i] || (rec_io[i] & exp_oe[i]) !== exp_io[i]) bad++;
    chk(bad == 0, htag, bad, 0);
    bad = 0;
    for (int i = hdr_n; i < hdr_n + lat; i++) if (rec_oe[i] !== 4'h0) bad++;
    chk(bad == 0, "R7 turnaround", bad, 0);
    bad = 0;
    for (int i = hdr_n + lat; i < hdr_n + lat + 2 * (len + 1); i++) if (rec_oe[i] !== 4'h0) bad++;
    chk(bad == 0, "R8 data oe", bad, 0);
    chk(rise_cnt == hdr_n + lat + 2 * (len + 1), "R9 edge count", rise_cnt, hdr_n + lat + 2 * (len + 1));
    chk(nb == len + 1, "R8 byte count", nb, len + 1);
    bad = 0;
    for (int i = 0; i <= len && i < 16; i++) if (got[i] !== fdat(addr + 24'(i))) bad++;
    chk(bad == 0, "R8 byte values", bad, 0);
    chk(bad_pulse == 0, "R8 valid pulse", bad_pulse, 0);
    exp_imp = quadp && (kind == 2);
    chk(implied_o == exp_imp, "R5 implied flag", implied_o, exp_imp);
    chk(t_r0 - t_cs == 20.0, "R2 select lead", int'(t_r0 - t_cs), 20);
    chk(t_r1 - t_r0 == 40.0, "R2 sclk period", int'(t_r1 - t_r0), 40);
    chk(req_ready_o == 1'b1, "R9 idle after", req_ready_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int kinds [6] = '{0, 2, 2, 1, 2, 0};
    int lens  [3] = '{0, 1, 5};
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 cs", cs_no, 1);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    chk(io_oe_o == 4'h0, "R1 oe", io_oe_o, 0);
    chk(rd_valid_o == 1'b0, "R1 valid", rd_valid_o, 0);
    chk(implied_o == 1'b0, "R1 implied", implied_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    for (int lat = 0; lat < 16; lat++)
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 6; s++)
          run(kinds[s], 24'h13579B * 24'(lat * 18 + l * 6 + s + 1), lens[l], lat);
    run(3, 24'hFFFFFE, 3, 2);
    run(0, 24'h000000, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule